// File: doc/BRIEF.md
# Fetch Target Buffer

This block is a small direct-mapped cache that the fetch stage reads every cycle with the raw fetch address. It does not wait for decode, so it does not know whether the fetched word is a branch. On a hit it returns the stored target as the next fetch address in the same cycle. This makes a taken branch cost zero cycles. On a miss it returns the sequential address, the fetch address plus 4.

Branch resolution drives the buffer's second port, which carries the address of the branch, its outcome and the computed target:
- A branch that resolved as taken is written into the slot its address selects. Any older occupant of that slot is overwritten.
- A branch that resolved as not-taken clears the slot, but only if that slot currently holds this same branch.

Writes take effect at the next clock edge. A lookup in the same cycle as a write therefore still sees the previous contents.

Top module: `fetch_target_buffer`

## Requirements
- R1: After a synchronous active-low reset every slot is empty, so every lookup misses.
- R2: On a miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`, wrapping modulo 2^32.
- R3: A taken resolution (`res_valid`=1, `res_taken`=1) stores the branch address and target. From the next cycle on, a lookup of that address has `pred_hit`=1 and `pred_next_pc` equal to the stored target.
- R4: The lookup result is combinational in `fetch_pc`. The prediction appears in the same cycle as the address, with no register in the path.
- R5: The slot index is address bits [5:2] and the tag is bits [31:6]. Bits [1:0] are not compared. Two addresses with the same index and different tags share one slot: the later taken resolution evicts the earlier one, and a lookup of the evicted address misses.
- R6: A not-taken resolution (`res_valid`=1, `res_taken`=0) whose address matches the valid tag in its slot clears that slot. A lookup of that address misses from the next cycle on.
- R7: A not-taken resolution whose tag does not match the slot's tag leaves the slot and its target unchanged.
- R8: When a resolution and a lookup select the same slot in one cycle, the lookup returns the contents from before that resolution.
- R9: While `res_valid` is 0, no slot changes, whatever the other resolution inputs carry.
- R10: A taken resolution of an address that is already stored replaces its target with the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch address found in the buffer |
| pred_next_pc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A branch resolution is presented this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | 1 if the branch was taken |
| res_target | input | 32 | Computed target of the resolved branch |

## Verification
The bench sets up an aliasing pair of addresses that share slot 1. It checks that the second taken resolution evicts the first, which a design comparing too few tag bits would fail by reporting a false hit. A not-taken resolution is sent for the evicted alias to confirm the resident entry survives. A design that clears slots by index alone would drop that entry. Same-cycle write and lookup of one slot are checked to return the old contents, which catches a write-through bypass. Further vectors cover a request with the valid bit low that carries live-looking fields, the top slot with a `+4` that wraps, and a mid-run reset that must empty a populated buffer.

// File: rtl/ftb_pkg.sv
// Package ftb_pkg
// Shared definitions for the fetch target buffer.
// Assumes word-aligned instructions, so address bits below WORD_LSB never
// take part in indexing or tag compare.
package ftb_pkg;

    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned SEQ_STEP = 4;

    // Action the update path applies to the slot selected by a resolution.
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_FILL = 2'd1,
        ACT_DROP = 2'd2
    } slot_act_e;

endpackage

// File: rtl/ftb_addr_split.sv
// Module ftb_addr_split
// Splits an address into a slot index and a tag.
// Assumes ADDR_W > IDX_W + LSB. The LSB bits below the index are discarded.
module ftb_addr_split #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned LSB    = 2,
    localparam int unsigned TAG_W = ADDR_W - IDX_W - LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // Field extraction: index just above the byte offset, tag above the index.
    always_comb begin
        idx = addr[LSB +: IDX_W];
        tag = addr[ADDR_W-1 -: TAG_W];
    end

endmodule

// File: rtl/ftb_entry_array.sv
// Module ftb_entry_array
// Direct-mapped slot storage: one valid bit, a tag and a target per slot.
// There are two combinational read ports, one for fetch lookup and one that
// probes the slot a resolution targets, and one write port that is applied
// at the clock edge. Reads therefore always return the contents from before
// the write. Only valid bits are reset; tag and target are written on fill.
module ftb_entry_array
    import ftb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 26,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_target,
    input  logic [IDX_W-1:0]  pr_idx,
    output logic              pr_valid,
    output logic [TAG_W-1:0]  pr_tag,
    input  slot_act_e         wr_act,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);

    logic              vld_q [ENTRIES];
    logic [TAG_W-1:0]  tag_q [ENTRIES];
    logic [ADDR_W-1:0] tgt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        // Valid bit: cleared on reset, set by a fill, cleared by a drop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[e] <= 1'b0;
            end else if (wr_idx == IDX_W'(e)) begin
                if (wr_act == ACT_FILL) begin
                    vld_q[e] <= 1'b1;
                end else if (wr_act == ACT_DROP) begin
                    vld_q[e] <= 1'b0;
                end
            end
        end

        // Payload: tag and target captured only when the slot is filled.
        always_ff @(posedge clk) begin
            if (wr_act == ACT_FILL && wr_idx == IDX_W'(e)) begin
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_target;
            end
        end
    end

    // Lookup read port: old contents, no bypass of the pending write.
    always_comb begin
        rd_valid  = vld_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_target = tgt_q[rd_idx];
    end

    // Probe read port used by the resolution path to decide on a drop.
    always_comb begin
        pr_valid = vld_q[pr_idx];
        pr_tag   = tag_q[pr_idx];
    end

endmodule

// File: rtl/ftb_update_ctl.sv
// Module ftb_update_ctl
// Turns a branch resolution into a slot action. A taken branch always fills
// its slot and evicts any other occupant. A not-taken branch drops the slot
// only when the slot holds that same branch.
// Assumes the probe inputs describe the slot selected by the resolution address.
module ftb_update_ctl
    import ftb_pkg::*;
#(
    parameter int unsigned TAG_W = 26
) (
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic [TAG_W-1:0] res_tag,
    input  logic             pr_valid,
    input  logic [TAG_W-1:0] pr_tag,
    output slot_act_e        act
);

    logic owner_match;

    // Ownership test: does the probed slot belong to this branch?
    always_comb owner_match = pr_valid && (pr_tag == res_tag);

    // Action select: fill on taken, drop on an owned not-taken, otherwise none.
    always_comb begin
        act = ACT_NONE;
        if (res_valid) begin
            if (res_taken) begin
                act = ACT_FILL;
            end else if (owner_match) begin
                act = ACT_DROP;
            end
        end
    end

endmodule

// File: rtl/fetch_target_buffer.sv
// Module fetch_target_buffer
// Top level: a direct-mapped buffer of branch targets, read every cycle with
// the fetch address. A hit returns the stored target and a miss returns the
// sequential address. Resolutions from later in the pipeline fill or drop
// slots at the next clock edge.
// Assumes at most one resolution per cycle and word-aligned addresses.
module fetch_target_buffer
    import ftb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - WORD_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target
);

    logic [IDX_W-1:0]  look_idx, upd_idx;
    logic [TAG_W-1:0]  look_tag, upd_tag;
    logic              rd_valid, pr_valid;
    logic [TAG_W-1:0]  rd_tag, pr_tag;
    logic [ADDR_W-1:0] rd_target;
    slot_act_e         act;

    ftb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LSB(WORD_LSB)) u_split_look (
        .addr (fetch_pc),
        .idx  (look_idx),
        .tag  (look_tag)
    );

    ftb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LSB(WORD_LSB)) u_split_upd (
        .addr (res_pc),
        .idx  (upd_idx),
        .tag  (upd_tag)
    );

    ftb_entry_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (look_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .pr_idx    (upd_idx),
        .pr_valid  (pr_valid),
        .pr_tag    (pr_tag),
        .wr_act    (act),
        .wr_idx    (upd_idx),
        .wr_tag    (upd_tag),
        .wr_target (res_target)
    );

    ftb_update_ctl #(.TAG_W(TAG_W)) u_upd (
        .res_valid (res_valid),
        .res_taken (res_taken),
        .res_tag   (upd_tag),
        .pr_valid  (pr_valid),
        .pr_tag    (pr_tag),
        .act       (act)
    );

    // Prediction: stored target on a tag hit, sequential address otherwise.
    always_comb begin
        pred_hit     = rd_valid && (rd_tag == look_tag);
        pred_next_pc = pred_hit ? rd_target : fetch_pc + ADDR_W'(SEQ_STEP);
    end

endmodule

// File: rtl/fetch_target_buffer_chk.sv
// Module fetch_target_buffer_chk
// Port-level temporal checks for fetch_target_buffer, attached with bind.
// Assumes the checker sees the same clock and reset as the buffer.
module fetch_target_buffer_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pc,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pred_hit);

    // R3
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken) |=>
            ((fetch_pc == $past(res_pc)) -> (pred_hit && pred_next_pc == $past(res_target))));

    // R6
    drop_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |=> ((fetch_pc == $past(res_pc)) -> !pred_hit));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ((fetch_pc == $past(fetch_pc)) ->
            ($stable(pred_hit) && $stable(pred_next_pc))));

endmodule

bind fetch_target_buffer fetch_target_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_next_pc (pred_next_pc),
    .res_valid    (res_valid),
    .res_pc       (res_pc),
    .res_taken    (res_taken),
    .res_target   (res_target)
);

// File: tb/fetch_target_buffer_bench.sv
module fetch_target_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;

    always #10 clk = ~clk;

    fetch_target_buffer u_fetch_target_buffer (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .pred_hit     (pred_hit),
        .pred_next_pc (pred_next_pc),
        .res_valid    (res_valid),
        .res_pc       (res_pc),
        .res_taken    (res_taken),
        .res_target   (res_target)
    );

    // op: 0 idle (fields still driven), 1 taken, 2 not-taken
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] rpc;
        logic [31:0] rtgt;
        logic [31:0] lpc;
        logic        ehit;
        logic [31:0] enext;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h0, 32'h0, 32'h0000_1004, 1'b0, 32'h0000_1008},               // R2 empty miss
        '{2'd1, 32'h0000_1004, 32'h0000_2000, 32'h0000_1004, 1'b0, 32'h0000_1008}, // R8 old contents
        '{2'd0, 32'h0, 32'h0, 32'h0000_1004, 1'b1, 32'h0000_2000},               // R3 hit
        '{2'd0, 32'h0, 32'h0, 32'h0000_1044, 1'b0, 32'h0000_1048},               // R5 alias misses
        '{2'd1, 32'h0000_1044, 32'h0000_3000, 32'h0000_1004, 1'b1, 32'h0000_2000}, // R8 evict pending
        '{2'd0, 32'h0, 32'h0, 32'h0000_1004, 1'b0, 32'h0000_1008},               // R5 evicted
        '{2'd0, 32'h0, 32'h0, 32'h0000_1044, 1'b1, 32'h0000_3000},               // R5 new owner
        '{2'd1, 32'h0000_1044, 32'h0000_3100, 32'h0000_2008, 1'b0, 32'h0000_200C}, // R2 other slot
        '{2'd0, 32'h0, 32'h0, 32'h0000_1044, 1'b1, 32'h0000_3100},               // R10 retarget
        '{2'd2, 32'h0000_1004, 32'h0, 32'h0000_1044, 1'b1, 32'h0000_3100},       // R7 foreign drop
        '{2'd0, 32'h0, 32'h0, 32'h0000_1044, 1'b1, 32'h0000_3100},               // R7 survives
        '{2'd2, 32'h0000_1044, 32'h0, 32'h0000_1044, 1'b1, 32'h0000_3100},       // R8 drop pending
        '{2'd0, 32'h0, 32'h0, 32'h0000_1044, 1'b0, 32'h0000_1048},               // R6 dropped
        '{2'd0, 32'h0000_2008, 32'h0000_4000, 32'h0000_2008, 1'b0, 32'h0000_200C}, // R9 idle fields
        '{2'd0, 32'h0, 32'h0, 32'h0000_2008, 1'b0, 32'h0000_200C},               // R9 no fill
        '{2'd1, 32'hFFFF_FFFC, 32'h0000_0100, 32'hFFFF_FFFC, 1'b0, 32'h0000_0000}, // R2 wrap
        '{2'd0, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b1, 32'h0000_0100},               // R4 top slot hit
        '{2'd0, 32'h0, 32'h0, 32'hFFFF_FFBC, 1'b0, 32'hFFFF_FFC0}                // R5 top alias
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge and check the combinational result before the rising edge.
    task automatic step(input logic [1:0] op, input logic [31:0] rpc, input logic [31:0] rtgt,
                        input logic [31:0] lpc, input logic ehit, input logic [31:0] enext,
                        input string req);
        @(negedge clk);
        res_valid  = (op != 2'd0);
        res_taken  = (op == 2'd1) || (op == 2'd0);
        res_pc     = rpc;
        res_target = rtgt;
        fetch_pc   = lpc;
        #2;
        check({req, " hit"}, 32'(pred_hit), 32'(ehit));
        check({req, " next"}, pred_next_pc, enext);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R4 same-cycle result
        step(2'd0, 32'h0, 32'h0, 32'h0000_0040, 1'b0, 32'h0000_0044, "R1");
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].rpc, VEC[i].rtgt, VEC[i].lpc, VEC[i].ehit, VEC[i].enext,
                 $sformatf("R4 vec%0d", i));
        end
        // R3 fill slot 3, then a mid-run reset must empty it (R1)
        step(2'd1, 32'h0000_500C, 32'h0000_6000, 32'h0, 1'b0, 32'h4, "R3 fill");
        step(2'd0, 32'h0, 32'h0, 32'h0000_500C, 1'b1, 32'h0000_6000, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(2'd0, 32'h0, 32'h0, 32'h0000_500C, 1'b0, 32'h0000_5010, "R1 after reset");
        step(2'd0, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b0, 32'h0000_0000, "R1 top slot");
        // R5 low address bits are not compared
        step(2'd1, 32'h0000_7010, 32'h0000_8000, 32'h0, 1'b0, 32'h4, "R5 fill");
        step(2'd0, 32'h0, 32'h0, 32'h0000_7013, 1'b1, 32'h0000_8000, "R5 low bits");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule